// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This execution unit sits beside the integer pipeline of a 32-bit RISC core and runs the multiply-accumulate family of register-to-register instructions. The issue stage presents the decoded instruction word together with the two source register values and pulses `start`. The unit multiplies the operands in a multi-cycle shift-add engine. It then folds the product into an accumulator held in two registers, HI and LO, and hands back one destination value with a one-cycle write enable.

A five-bit sub-operation field selects the variant. Bit 0 chooses unsigned arithmetic. Bit 2 chooses a plain multiply that loads the accumulator instead of adding to it. Bit 3 returns the upper half rather than the lower half. Bit 4 clamps the sum. Bit 1 must be zero. The function code chooses between the wide forms, which work on the whole HI:LO pair, and the single forms, which work on LO alone and leave HI untouched. The accumulator halves are also visible on output ports, so move-from-accumulator instructions can read them.

The operand width is the parameter `DW` (32 in the core). The accumulator is `2*DW` bits wide, and every limit quoted below scales with `DW`.

Top module: `sat_mac_unit`

## Requirements
- R1: An instruction is accepted only when bits [31:26] are 000000. The destination index in bits [15:11] is returned on `rd_idx` with the result. Bits [25:16] do not affect the result, because the operands arrive on `src_a` and `src_b`.
- R2: Function code 101000 with sub-op 00000 (signed) or 00001 (unsigned) replaces HI:LO with HI:LO plus the full `2*DW`-bit product of the sign- or zero-extended operands, wrapping modulo 2^(2*DW). LO is returned.
- R3: With function 101000, sub-ops 01000, 11000, 01001 and 11001 perform the same update as their counterparts with bit 3 clear, but return the new HI instead of LO.
- R4: Signed saturating forms (sub-op bit 4 set, bit 0 clear) clamp a sum above 2^(DW-1)-1 to 2^(DW-1)-1, and a sum below -2^(DW-1) to -2^(DW-1). The clamped value is sign-extended over HI:LO.
- R5: Unsigned saturating forms (bits 4 and 0 set) force every accumulator bit to one when the unsigned sum exceeds 2^(DW-1)-1.
- R6: Function 101001 with sub-op 00000 (signed) or 00001 (unsigned) sets LO to the low `DW` bits of LO plus the product, with LO sign- or zero-extended. HI is left unchanged, and the new LO is returned.
- R7: Function 101001 with sub-op 10000 or 10001 applies the R4 or R5 clamp to that single-register sum before writing LO.
- R8: With function 101000, sub-ops 00100 (signed) and 00101 (unsigned) load HI:LO with the product and return LO. Sub-ops 01100 and 01101 do the same but return HI.
- R9: Every other combination of opcode, function and sub-op raises `done` one clock edge after acceptance, with `rd_we` low and HI and LO unchanged.
- R10: For an accepted valid instruction, `done` and `rd_we` rise together `DW+1` clock edges after the edge that accepted `start`. Both last exactly one cycle. `busy` is high from the cycle after acceptance through the `done` cycle.
- R11: A `start` pulse while `busy` is high is ignored.
- R12: After reset, HI and LO read zero and `busy`, `done` and `rd_we` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Issue strobe; sampled only when idle |
| instr | input | 32 | Instruction word |
| src_a | input | DW | First source register value |
| src_b | input | DW | Second source register value |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| rd_we | output | 1 | Destination write enable, pulses with `done` |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | DW | Destination value |
| acc_hi | output | DW | Current HI register |
| acc_lo | output | DW | Current LO register |

## Verification
HI and LO are visible on the ports, so a wrong accumulator update shows in the very cycle `done` rises. Because every sweep step preloads the accumulator with a known product, any corrupted history also shows on the next operation. A multiplier that takes the wrong number of steps, or mis-handles operand signs, shows as a wrong `done` latency or a wrong product in that same completion cycle. A decode fault appears as a missing or spurious `rd_we`, or as HI moving on a single-register form.

// File: rtl/smac_pkg.sv
// Shared encodings and types for the saturating multiply-accumulate unit.
// Assumes the instruction layout: opcode [31:26], dest [15:11],
// sub-op [10:6], function [5:0].
package smac_pkg;

    localparam logic [5:0] OPC_REG  = 6'b000000;
    localparam logic [5:0] FN_WIDE  = 6'b101000;
    localparam logic [5:0] FN_SINGLE = 6'b101001;

    // Decoded control for one instruction
    typedef struct packed {
        logic ok;        // listed combination
        logic mul_only;  // load product instead of accumulating
        logic uns;       // unsigned arithmetic
        logic sat;       // clamp the sum
        logic hi_sel;    // return the upper half
        logic single;    // LO-only form
    } smac_ctrl_t;

    typedef enum logic [1:0] {
        SM_IDLE = 2'd0,
        SM_MUL  = 2'd1,
        SM_FIN  = 2'd2
    } smac_state_t;

endpackage

// File: rtl/smac_decode.sv
// Instruction decoder. Purely combinational: it maps opcode, function
// and sub-op bits to control flags and flags unlisted combinations.
// Assumes the field positions defined in smac_pkg.
module smac_decode
    import smac_pkg::*;
(
    input  logic [5:0]  opc_i,
    input  logic [4:0]  sub_i,
    input  logic [5:0]  fn_i,
    output smac_ctrl_t  ctrl_o
);

    logic is_wide;
    logic is_single;
    logic wide_ok;
    logic single_ok;

    assign is_wide   = (fn_i == FN_WIDE);
    assign is_single = (fn_i == FN_SINGLE);

    // Wide forms: bit 1 clear, multiply-only never saturates
    assign wide_ok   = is_wide && !sub_i[1] && !(sub_i[2] && sub_i[4]);
    // Single forms: only the sign and saturate bits may be set
    assign single_ok = is_single && !sub_i[1] && !sub_i[2] && !sub_i[3];

    // Assemble the control word from the sub-op bits
    always_comb begin
        ctrl_o.ok       = (opc_i == OPC_REG) && (wide_ok || single_ok);
        ctrl_o.uns      = sub_i[0];
        ctrl_o.mul_only = sub_i[2];
        ctrl_o.hi_sel   = sub_i[3];
        ctrl_o.sat      = sub_i[4];
        ctrl_o.single   = is_single;
    end

endmodule

// File: rtl/smac_shift_mul.sv
// Iterative shift-add multiplier. It multiplies operand magnitudes in
// DW steps, one multiplier bit per clock, then restores the sign.
// Assumes load_i is asserted only while the unit is idle. prod_o is valid
// while fin_o is high and stays stable until the next load.
module smac_shift_mul #(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    input  logic            signed_i,
    output logic            fin_o,
    output logic [2*DW-1:0] prod_o
);

    localparam int W2 = 2 * DW;
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    logic [W2-1:0] mcand;
    logic [DW-1:0] mplier;
    logic [W2-1:0] part;
    logic          neg;
    logic          run;
    logic [CW-1:0] cnt;
    logic          fin_q;
    logic [DW-1:0] mag_a;
    logic [DW-1:0] mag_b;

    // Operand magnitudes for the signed case
    assign mag_a = (signed_i && a_i[DW-1]) ? (~a_i + 1'b1) : a_i;
    assign mag_b = (signed_i && b_i[DW-1]) ? (~b_i + 1'b1) : b_i;

    // Load operands, then add one shifted partial product per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand  <= '0;
            mplier <= '0;
            part   <= '0;
            neg    <= 1'b0;
            run    <= 1'b0;
            cnt    <= '0;
            fin_q  <= 1'b0;
        end else if (load_i) begin
            mcand  <= {{DW{1'b0}}, mag_a};
            mplier <= mag_b;
            part   <= '0;
            neg    <= signed_i && (a_i[DW-1] ^ b_i[DW-1]);
            run    <= 1'b1;
            cnt    <= '0;
            fin_q  <= 1'b0;
        end else if (run) begin
            if (mplier[0]) begin
                part <= part + mcand;
            end
            mcand  <= mcand << 1;
            mplier <= mplier >> 1;
            cnt    <= cnt + 1'b1;
            if (cnt == LAST) begin
                run   <= 1'b0;
                fin_q <= 1'b1;
            end
        end else begin
            fin_q <= 1'b0;
        end
    end

    assign fin_o  = fin_q;
    assign prod_o = neg ? (~part + 1'b1) : part;

    AST_MUL_FIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !fin_o); // R10
    AST_MUL_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < CW'(DW))); // R10

endmodule

// File: rtl/smac_acc_combine.sv
// Accumulator update path. It extends the accumulator and product into one
// spare bit of headroom, adds them, applies the selected clamp and splits
// the result into the new HI, LO and return value. Combinational.
// Assumes ctrl_i is a listed combination; otherwise the result is unused.
module smac_acc_combine
    import smac_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]   hi_i,
    input  logic [DW-1:0]   lo_i,
    input  logic [2*DW-1:0] prod_i,
    input  smac_ctrl_t      ctrl_i,
    output logic [DW-1:0]   hi_o,
    output logic [DW-1:0]   lo_o,
    output logic [DW-1:0]   rd_o
);

    localparam int W2 = 2 * DW;
    localparam int WS = W2 + 1;

    logic          sgn;
    logic [WS-1:0] acc_ext;
    logic [WS-1:0] prod_ext;
    logic [WS-1:0] sum;
    logic [WS-1:0] lim_pos;
    logic [WS-1:0] lim_neg;
    logic [WS-1:0] clamped;

    assign sgn     = !ctrl_i.uns;
    assign lim_pos = {{(WS - DW + 1){1'b0}}, {(DW - 1){1'b1}}};
    assign lim_neg = ~lim_pos;

    // Widen the old accumulator (whole pair or LO alone) and the product
    always_comb begin
        if (ctrl_i.mul_only) begin
            acc_ext = '0;
        end else if (ctrl_i.single) begin
            acc_ext = {{(WS - DW){sgn & lo_i[DW-1]}}, lo_i};
        end else begin
            acc_ext = {sgn & hi_i[DW-1], hi_i, lo_i};
        end
        prod_ext = {sgn & prod_i[W2-1], prod_i};
    end

    assign sum = acc_ext + prod_ext;

    // Clamp the sum to the signed range, or to all ones when unsigned
    always_comb begin
        clamped = sum;
        if (ctrl_i.sat) begin
            if (sgn) begin
                if ($signed(sum) > $signed(lim_pos)) begin
                    clamped = lim_pos;
                end else if ($signed(sum) < $signed(lim_neg)) begin
                    clamped = lim_neg;
                end
            end else if (sum > lim_pos) begin
                clamped = '1;
            end
        end
    end

    // Route the clamped value to HI, LO and the destination
    always_comb begin
        if (ctrl_i.single) begin
            hi_o = hi_i;
            lo_o = clamped[DW-1:0];
            rd_o = clamped[DW-1:0];
        end else begin
            hi_o = clamped[W2-1:DW];
            lo_o = clamped[DW-1:0];
            rd_o = ctrl_i.hi_sel ? clamped[W2-1:DW] : clamped[DW-1:0];
        end
    end

    wire unused_top = clamped[WS-1];

endmodule

// File: rtl/sat_mac_unit.sv
// Saturating multiply-accumulate unit (top). It accepts one instruction
// while idle, multiplies in smac_shift_mul, updates HI/LO through
// smac_acc_combine and returns one destination value with done.
// Assumes the issue logic holds off dependent work while busy is high.
module sat_mac_unit
    import smac_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [31:0]   instr,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    output logic          busy,
    output logic          done,
    output logic          rd_we,
    output logic [4:0]    rd_idx,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] acc_hi,
    output logic [DW-1:0] acc_lo
);

    localparam int W2 = 2 * DW;

    smac_state_t   state;
    smac_ctrl_t    dec;
    smac_ctrl_t    op_q;
    logic [4:0]    idx_q;
    logic [DW-1:0] hi_q;
    logic [DW-1:0] lo_q;
    logic [DW-1:0] rd_q;
    logic          we_q;
    logic          accept;
    logic          mul_load;
    logic          mul_fin;
    logic [W2-1:0] product;
    logic [DW-1:0] nxt_hi;
    logic [DW-1:0] nxt_lo;
    logic [DW-1:0] nxt_rd;

    smac_decode u_decode (
        .opc_i  (instr[31:26]),
        .sub_i  (instr[10:6]),
        .fn_i   (instr[5:0]),
        .ctrl_o (dec)
    );

    assign accept   = (state == SM_IDLE) && start;
    assign mul_load = accept && dec.ok;

    smac_shift_mul #(.DW(DW)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (mul_load),
        .a_i      (src_a),
        .b_i      (src_b),
        .signed_i (!dec.uns),
        .fin_o    (mul_fin),
        .prod_o   (product)
    );

    smac_acc_combine #(.DW(DW)) u_comb (
        .hi_i   (hi_q),
        .lo_i   (lo_q),
        .prod_i (product),
        .ctrl_i (op_q),
        .hi_o   (nxt_hi),
        .lo_o   (nxt_lo),
        .rd_o   (nxt_rd)
    );

    // Sequence idle -> multiply -> finish and commit the accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SM_IDLE;
            op_q  <= '0;
            idx_q <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
            rd_q  <= '0;
            we_q  <= 1'b0;
        end else begin
            case (state)
                SM_IDLE: begin
                    if (start) begin
                        op_q  <= dec;
                        idx_q <= instr[15:11];
                        we_q  <= 1'b0;
                        state <= dec.ok ? SM_MUL : SM_FIN;
                    end
                end
                SM_MUL: begin
                    if (mul_fin) begin
                        hi_q  <= nxt_hi;
                        lo_q  <= nxt_lo;
                        rd_q  <= nxt_rd;
                        we_q  <= 1'b1;
                        state <= SM_FIN;
                    end
                end
                SM_FIN: begin
                    we_q  <= 1'b0;
                    state <= SM_IDLE;
                end
                default: state <= SM_IDLE;
            endcase
        end
    end

    assign busy    = (state != SM_IDLE);
    assign done    = (state == SM_FIN);
    assign rd_we   = done && we_q;
    assign rd_idx  = idx_q;
    assign rd_data = rd_q;
    assign acc_hi  = hi_q;
    assign acc_lo  = lo_q;

    AST_WE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> done); // R10
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_BUSY_COVERS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R10
    AST_SINGLE_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q.single) |-> $stable(acc_hi)); // R6
    AST_BAD_OP_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rd_we) |-> ($stable(acc_hi) && $stable(acc_lo))); // R9
    AST_SIGNED_CLAMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we && op_q.sat && !op_q.uns && !op_q.single)
            |-> (acc_hi == {DW{acc_lo[DW-1]}})); // R4
    AST_UNSIGNED_CLAMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we && op_q.sat && op_q.uns && !op_q.single)
            |-> ((acc_hi == '0 && !acc_lo[DW-1]) || (&{acc_hi, acc_lo}))); // R5

endmodule

// File: tb/sat_mac_unit_bench.sv
// Sweep bench: DW=4, every listed instruction against every operand pair,
// with the accumulator preloaded by a known product before each step.
module sat_mac_unit_bench;

    localparam int DW = 4;
    localparam longint M1 = (64'sd1 << DW) - 1;
    localparam longint M2 = (64'sd1 << (2 * DW)) - 1;
    localparam longint MAXP = (64'sd1 << (DW - 1)) - 1;
    localparam longint MINN = -(64'sd1 << (DW - 1));

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [31:0]   instr = '0;
    logic [DW-1:0] src_a = '0;
    logic [DW-1:0] src_b = '0;
    logic          busy, done, rd_we;
    logic [4:0]    rd_idx;
    logic [DW-1:0] rd_data, acc_hi, acc_lo;

    int total = 0;
    int bad = 0;
    longint m_hi = 0;
    longint m_lo = 0;

    always #4 clk = ~clk;

    sat_mac_unit #(.DW(DW)) u_sat_mac_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .src_a(src_a), .src_b(src_b), .busy(busy), .done(done),
        .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data),
        .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sx(input longint v, input int w);
        return v[w-1] ? v - (64'sd1 << w) : v;
    endfunction

    function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rd,
                                       input logic [4:0] sub, input logic [5:0] fn);
        return {opc, 5'd3, 5'd7, rd, sub, fn};
    endfunction

    // Expected outcome from the requirements; updates the model accumulator
    task automatic predict(input logic [31:0] ins, input longint a, input longint b,
                           output bit ok, output longint rd_exp, output string tag);
        logic [4:0] sub = ins[10:6];
        logic [5:0] fn = ins[5:0];
        bit u = sub[0], sat = sub[4], hs = sub[3], mul = 0, sgl = 0;
        longint p, s, t;
        ok = 0;
        rd_exp = 0;
        tag = "R9";
        if (ins[31:26] == 6'b000000 && fn == 6'b101000) begin
            case (sub)
                5'b00000, 5'b10000, 5'b00001, 5'b10001,
                5'b01000, 5'b11000, 5'b01001, 5'b11001: ok = 1;
                5'b00100, 5'b00101, 5'b01100, 5'b01101: begin ok = 1; mul = 1; end
                default: ok = 0;
            endcase
        end else if (ins[31:26] == 6'b000000 && fn == 6'b101001) begin
            case (sub)
                5'b00000, 5'b10000, 5'b00001, 5'b10001: begin ok = 1; sgl = 1; end
                default: ok = 0;
            endcase
        end
        if (!ok) return;
        p = (u ? a : sx(a, DW)) * (u ? b : sx(b, DW));
        if (mul) s = p;
        else if (sgl) s = (u ? m_lo : sx(m_lo, DW)) + p;
        else s = (u ? ((m_hi << DW) | m_lo) : sx((m_hi << DW) | m_lo, 2 * DW)) + p;
        if (sat) begin
            if (!u) begin
                if (s > MAXP) s = MAXP;
                else if (s < MINN) s = MINN;
            end else if (s > MAXP) s = -1;
        end
        if (sgl) begin
            m_lo = s & M1;
            rd_exp = m_lo;
            tag = sat ? "R7" : "R6";
        end else begin
            t = s & M2;
            m_hi = t >> DW;
            m_lo = t & M1;
            rd_exp = hs ? m_hi : m_lo;
            tag = mul ? "R8" : sat ? (u ? "R5" : "R4") : hs ? "R3" : "R2";
        end
    endtask

    // Issue one instruction, optionally poke start while busy, and check it
    task automatic run(input logic [31:0] ins, input logic [DW-1:0] a,
                       input logic [DW-1:0] b, input bit poke);
        bit ok;
        longint exp_rd;
        string tag;
        int cyc;
        predict(ins, longint'(a), longint'(b), ok, exp_rd, tag);
        if (poke) tag = "R11";
        @(negedge clk);
        instr = ins; src_a = a; src_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        check(busy === 1'b1, "R10 busy after start", longint'(busy), 1);
        while (done !== 1'b1 && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 2) begin
                instr = mk(6'b0, 5'd9, 5'b00101, 6'b101000);
                src_a = ~a; src_b = ~b; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        check(cyc == (ok ? DW + 2 : 1), ok ? "R10 latency" : "R9 latency", cyc, ok ? DW + 2 : 1);
        check(rd_we === ok, ok ? "R10 rd_we" : "R9 rd_we", longint'(rd_we), longint'(ok));
        if (ok) begin
            check(longint'(rd_data) == exp_rd, {tag, " rd_data"}, longint'(rd_data), exp_rd);
            check(rd_idx == ins[15:11], "R1 rd_idx", longint'(rd_idx), longint'(ins[15:11]));
        end
        check(longint'(acc_hi) == m_hi, {tag, " acc_hi"}, longint'(acc_hi), m_hi);
        check(longint'(acc_lo) == m_lo, {tag, " acc_lo"}, longint'(acc_lo), m_lo);
        start = 1'b0;
        @(negedge clk);
        check(done === 1'b0 && rd_we === 1'b0, "R10 done single cycle",
              longint'({done, rd_we}), 0);
        check(busy === 1'b0, poke ? "R11 idle after run" : "R10 idle after run",
              longint'(busy), 0);
    endtask

    logic [10:0] ops [16] = '{
        {5'b00000, 6'b101000}, {5'b10000, 6'b101000}, {5'b00001, 6'b101000},
        {5'b10001, 6'b101000}, {5'b01000, 6'b101000}, {5'b11000, 6'b101000},
        {5'b01001, 6'b101000}, {5'b11001, 6'b101000}, {5'b00100, 6'b101000},
        {5'b00101, 6'b101000}, {5'b01100, 6'b101000}, {5'b01101, 6'b101000},
        {5'b00000, 6'b101001}, {5'b10000, 6'b101001}, {5'b00001, 6'b101001},
        {5'b10001, 6'b101001}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check(busy === 1'b0 && done === 1'b0 && rd_we === 1'b0, "R12 control idle",
              longint'({busy, done, rd_we}), 0);
        check(acc_hi === '0 && acc_lo === '0, "R12 accumulator clear",
              longint'({acc_hi, acc_lo}), 0);

        // R2 directed: -3 * 5 into a zero accumulator
        run(mk(6'b0, 5'd4, 5'b00000, 6'b101000), 4'hD, 4'h5, 1'b0);
        // R9: unlisted sub-ops and function codes
        run(mk(6'b0, 5'd5, 5'b00010, 6'b101000), 4'h7, 4'h7, 1'b0);
        run(mk(6'b0, 5'd5, 5'b01000, 6'b101001), 4'h7, 4'h7, 1'b0);
        run(mk(6'b0, 5'd5, 5'b10100, 6'b101000), 4'h7, 4'h7, 1'b0);
        run(mk(6'b0, 5'd5, 5'b00000, 6'b011000), 4'h7, 4'h7, 1'b0);
        // R1: nonzero opcode is rejected
        run(mk(6'b000001, 5'd5, 5'b00000, 6'b101000), 4'h7, 4'h7, 1'b0);
        // R11: start during busy is ignored
        run(mk(6'b0, 5'd6, 5'b01000, 6'b101000), 4'h3, 4'h6, 1'b1);
        run(mk(6'b0, 5'd6, 5'b10001, 6'b101001), 4'hF, 4'hF, 1'b1);

        // Sweep every listed form over all operand pairs
        for (int k = 0; k < 16; k++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    run(mk(6'b0, 5'(a + b), 5'b00100, 6'b101000), 4'(b), 4'(a + 5), 1'b0);
                    run(mk(6'b0, 5'(a ^ b), ops[k][10:6], ops[k][5:0]), 4'(a), 4'(b), 1'b0);
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule